// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, write back). Operands are read only in decode and results are written only in write back, so only read-after-write dependences need attention. Each cycle the unit compares the source register fields held in decode and in execute with the destinations of the older instructions further down the pipe. From that comparison it produces:

- multiplexer selects for the two ALU operands;
- a select for the operand of the branch test in decode;
- a single stall line;
- the redirect for a branch that resolves in decode.

When stall is high, the pipeline holds PC and the fetch/decode register and loads a no-op with all write enables cleared into execute. Conditional branches test one register for zero or non-zero. The test is done here on the forwarded operand. Every branch has one delay slot: the instruction after a branch always completes, and the redirect steers the fetch that follows it. The block is purely combinational. There is no data stream through it, so all pins are plain control and data signals with no handshake. The clock and reset pins serve only the embedded property checks.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An ALU operand select (`alu_a_sel` for `ex_src_a`, `alu_b_sel` for `ex_src_b`) is 2'b01 when the instruction in memory writes a register (`mem_wr_en`) equal to that source.
- R2: With no memory-stage match, the select is 2'b10 when the write-back instruction writes that source register, and 2'b00 (register file value) otherwise.
- R3: When both the memory and the write-back stage match a source, the memory stage wins (select 2'b01).
- R4: A source or destination of register 0 never matches: the select stays 2'b00 and no stall is raised on its account.
- R5: A load in execute (`ex_is_load`, `ex_wr_en`) whose destination equals a decode source flagged as used (`id_use_a`/`id_use_b`) raises `stall`. A matching source that is not flagged as used does not.
- R6: An ALU (non-load) result in execute never stalls a non-branch instruction in decode.
- R7: A branch in decode whose tested register (`id_src_a`) is written by the instruction in execute stalls. It also stalls when that register is written by a load in memory. A load directly ahead therefore costs two stall cycles and an ALU instruction one.
- R8: `br_sel` uses the R1 to R4 encoding for `id_src_a` while `id_is_branch` is high, and is 2'b00 otherwise. The tested value is `rf_a_data` for 2'b00, `exmem_result` for 2'b01 and `memwb_result` for 2'b10.
- R9: With a branch in decode and no stall, `redirect` is high exactly when the condition holds: the tested value is zero and `id_br_if_zero`=1, or the value is non-zero and `id_br_if_zero`=0. In that case `redirect_pc` equals `id_br_target`.
- R10: `redirect` is never high while `stall` is high or when no branch is in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_src_a | input | REG_AW | First source field in decode (the tested register for a branch) |
| id_src_b | input | REG_AW | Second source field in decode |
| id_use_a | input | 1 | Decode instruction reads its first source |
| id_use_b | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_br_if_zero | input | 1 | 1: taken if zero, 0: taken if non-zero |
| id_br_target | input | PC_W | Branch target computed in decode |
| rf_a_data | input | DATA_W | Register file value of id_src_a |
| ex_src_a | input | REG_AW | First source field in execute |
| ex_src_b | input | REG_AW | Second source field in execute |
| ex_dst | input | REG_AW | Destination in execute |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_AW | Destination in memory |
| mem_wr_en | input | 1 | Memory instruction writes a register |
| mem_is_load | input | 1 | Memory instruction is a load |
| exmem_result | input | DATA_W | ALU result held in the execute/memory register |
| wb_dst | input | REG_AW | Destination in write back |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| memwb_result | input | DATA_W | Result held in the memory/write-back register |
| alu_a_sel | output | 2 | First ALU operand select |
| alu_b_sel | output | 2 | Second ALU operand select |
| br_sel | output | 2 | Branch test operand select |
| stall | output | 1 | Hold PC and fetch/decode, inject a bubble into execute |
| redirect | output | 1 | Branch taken: next fetch after the delay slot uses redirect_pc |
| redirect_pc | output | PC_W | Target of a taken branch |

## Verification
The main stimulus is a long random stream over a small register range (0 to 3), so that many cycles match in one, two or three stages at once, often including register 0. That stream separates the priority of memory over write back from a single match, used from unused sources, and loads from ALU producers. Tested values are drawn with many zeros so that both branch senses resolve both ways. A directed walk moves a load down the pipe ahead of a dependent branch and shows the two stall cycles followed by resolution through the write-back path. A matching ALU producer gives exactly one stall cycle.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hfu_src_match.sv
module hfu_src_match
  import hfu_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr_en,
  output fwd_sel_e          sel
);
  logic src_live;
  logic hit_mem;
  logic hit_wb;

  // register 0 is hard-wired; it never takes a forwarded value
  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_wr_en && (mem_dst == src);
  assign hit_wb   = src_live && wb_wr_en && (wb_dst == src);

  always_comb begin
    if (hit_mem)     sel = FWD_EXMEM;  // youngest producer first
    else if (hit_wb) sel = FWD_MEMWB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hfu_stall_detect.sv
module hfu_stall_detect #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_use_a,
  input  logic              id_use_b,
  input  logic              id_is_branch,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr_en,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic              mem_is_load,
  output logic              stall
);
  logic ex_live;
  logic mem_load_live;
  logic load_use;
  logic br_on_ex;
  logic br_on_mem_load;

  assign ex_live       = ex_wr_en && (ex_dst != '0);
  assign mem_load_live = mem_wr_en && mem_is_load && (mem_dst != '0);

  // loaded data only exists at the end of memory: one bubble for users
  assign load_use = ex_live && ex_is_load &&
                    ((id_use_a && (id_src_a == ex_dst)) ||
                     (id_use_b && (id_src_b == ex_dst)));

  // the zero test sits in decode, so any producer in execute is too late,
  // and a load still in memory is too late as well
  assign br_on_ex       = id_is_branch && ex_live && (id_src_a == ex_dst);
  assign br_on_mem_load = id_is_branch && mem_load_live && (id_src_a == mem_dst);

  assign stall = load_use || br_on_ex || br_on_mem_load;
endmodule

// File: rtl/hfu_branch_resolve.sv
module hfu_branch_resolve
  import hfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              is_branch,
  input  logic              br_if_zero,
  input  logic              stall,
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [DATA_W-1:0] exmem_data,
  input  logic [DATA_W-1:0] memwb_data,
  input  logic [PC_W-1:0]   target,
  output logic              redirect,
  output logic [PC_W-1:0]   redirect_pc
);
  logic [DATA_W-1:0] operand;
  logic              is_zero;

  always_comb begin
    unique case (sel)
      FWD_EXMEM: operand = exmem_data;
      FWD_MEMWB: operand = memwb_data;
      default:   operand = rf_data;
    endcase
  end

  assign is_zero     = (operand == '0);
  assign redirect    = is_branch && !stall && (is_zero == br_if_zero);
  assign redirect_pc = target;
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hfu_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_use_a,
  input  logic              id_use_b,
  input  logic              id_is_branch,
  input  logic              id_br_if_zero,
  input  logic [PC_W-1:0]   id_br_target,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr_en,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic              mem_is_load,
  input  logic [DATA_W-1:0] exmem_result,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr_en,
  input  logic [DATA_W-1:0] memwb_result,
  output logic [1:0]        alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic [1:0]        br_sel,
  output logic              stall,
  output logic              redirect,
  output logic [PC_W-1:0]   redirect_pc
);
  localparam int N_ALU_SRC = 2;

  logic [REG_AW-1:0] alu_src [N_ALU_SRC];
  fwd_sel_e          alu_sel [N_ALU_SRC];
  fwd_sel_e          id_a_sel;
  fwd_sel_e          br_sel_e;

  assign alu_src[0] = ex_src_a;
  assign alu_src[1] = ex_src_b;

  for (genvar g = 0; g < N_ALU_SRC; g++) begin : g_alu_fwd
    hfu_src_match #(.REG_AW(REG_AW)) u_match (
      .src       (alu_src[g]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .wb_dst    (wb_dst),
      .wb_wr_en  (wb_wr_en),
      .sel       (alu_sel[g])
    );
  end

  assign alu_a_sel = alu_sel[0];
  assign alu_b_sel = alu_sel[1];

  hfu_src_match #(.REG_AW(REG_AW)) u_br_match (
    .src       (id_src_a),
    .mem_dst   (mem_dst),
    .mem_wr_en (mem_wr_en),
    .wb_dst    (wb_dst),
    .wb_wr_en  (wb_wr_en),
    .sel       (id_a_sel)
  );

  assign br_sel_e = id_is_branch ? id_a_sel : FWD_RF;
  assign br_sel   = br_sel_e;

  hfu_stall_detect #(.REG_AW(REG_AW)) u_stall (
    .id_src_a     (id_src_a),
    .id_src_b     (id_src_b),
    .id_use_a     (id_use_a),
    .id_use_b     (id_use_b),
    .id_is_branch (id_is_branch),
    .ex_dst       (ex_dst),
    .ex_wr_en     (ex_wr_en),
    .ex_is_load   (ex_is_load),
    .mem_dst      (mem_dst),
    .mem_wr_en    (mem_wr_en),
    .mem_is_load  (mem_is_load),
    .stall        (stall)
  );

  hfu_branch_resolve #(.DATA_W(DATA_W), .PC_W(PC_W)) u_branch (
    .is_branch   (id_is_branch),
    .br_if_zero  (id_br_if_zero),
    .stall       (stall),
    .sel         (br_sel_e),
    .rf_data     (rf_a_data),
    .exmem_data  (exmem_result),
    .memwb_data  (memwb_result),
    .target      (id_br_target),
    .redirect    (redirect),
    .redirect_pc (redirect_pc)
  );

  // R3: memory-stage producer wins over write back
  p_mem_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && ex_src_a != '0 && mem_dst == ex_src_a) |-> (alu_a_sel == 2'b01));

  // R4: register 0 is never a forwarding source
  p_reg0_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_b == '0) |-> (alu_b_sel == 2'b00));

  // R6: an ALU producer alone never stalls a non-branch consumer
  p_alu_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_is_branch && !ex_is_load) |-> !stall);

  // R7: branch on a load still in memory must wait
  p_load_branch_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_branch && id_src_a != '0 && mem_wr_en && mem_is_load && mem_dst == id_src_a)
      |-> stall);

  // R10: no redirect while frozen or without a branch
  p_redirect_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !id_is_branch) |-> !redirect);
endmodule

// File: tb/hazard_fwd_unit_tb.sv
`timescale 1ns/1ps
module hazard_fwd_unit_tb;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
  logic id_use_a, id_use_b, id_is_branch, id_br_if_zero;
  logic ex_wr_en, ex_is_load, mem_wr_en, mem_is_load, wb_wr_en;
  logic [PW-1:0] id_br_target, redirect_pc;
  logic [DW-1:0] rf_a_data, exmem_result, memwb_result;
  logic [1:0] alu_a_sel, alu_b_sel, br_sel;
  logic stall, redirect;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  hazard_fwd_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
    .id_is_branch(id_is_branch), .id_br_if_zero(id_br_if_zero), .id_br_target(id_br_target),
    .rf_a_data(rf_a_data), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
    .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .mem_is_load(mem_is_load), .exmem_result(exmem_result), .wb_dst(wb_dst),
    .wb_wr_en(wb_wr_en), .memwb_result(memwb_result), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .br_sel(br_sel), .stall(stall), .redirect(redirect),
    .redirect_pc(redirect_pc)
  );

  // ---- behavioural reference ----
  function automatic logic [1:0] ref_src(input logic [RW-1:0] r);
    if (r == 0) return 2'b00;
    if (mem_wr_en && mem_dst == r) return 2'b01;
    if (wb_wr_en && wb_dst == r) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic ref_stall();
    logic s;
    s = 1'b0;
    if (ex_wr_en && ex_is_load && ex_dst != 0) begin
      if (id_use_a && id_src_a == ex_dst) s = 1'b1;
      if (id_use_b && id_src_b == ex_dst) s = 1'b1;
    end
    if (id_is_branch && id_src_a != 0) begin
      if (ex_wr_en && ex_dst == id_src_a) s = 1'b1;
      if (mem_wr_en && mem_is_load && mem_dst == id_src_a) s = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [1:0] ref_br_sel();
    return id_is_branch ? ref_src(id_src_a) : 2'b00;
  endfunction

  function automatic logic ref_redirect();
    logic [DW-1:0] v;
    case (ref_br_sel())
      2'b01:   v = exmem_result;
      2'b10:   v = memwb_result;
      default: v = rf_a_data;
    endcase
    if (!id_is_branch || ref_stall()) return 1'b0;
    return ((v == 0) == id_br_if_zero);
  endfunction

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1/R2/R3/R4 alu_a_sel", alu_a_sel, ref_src(ex_src_a));
    chk("R1/R2/R3/R4 alu_b_sel", alu_b_sel, ref_src(ex_src_b));
    chk("R5/R6/R7 stall", stall, ref_stall());
    chk("R8 br_sel", br_sel, ref_br_sel());
    chk("R9/R10 redirect", redirect, ref_redirect());
    if (ref_redirect()) chk("R9 redirect_pc", redirect_pc, id_br_target);
  endtask

  task automatic idle();
    id_src_a = 0; id_src_b = 0; id_use_a = 0; id_use_b = 0;
    id_is_branch = 0; id_br_if_zero = 0; id_br_target = 0; rf_a_data = 0;
    ex_src_a = 0; ex_src_b = 0; ex_dst = 0; ex_wr_en = 0; ex_is_load = 0;
    mem_dst = 0; mem_wr_en = 0; mem_is_load = 0; exmem_result = 0;
    wb_dst = 0; wb_wr_en = 0; memwb_result = 0;
  endtask

  function automatic logic [DW-1:0] rnd_val();
    return ($urandom_range(0, 2) == 0) ? '0 : DW'($urandom_range(1, 9));
  endfunction

  task automatic randomize_inputs();
    id_src_a = RW'($urandom_range(0, 3)); id_src_b = RW'($urandom_range(0, 3));
    id_use_a = 1'($urandom); id_use_b = 1'($urandom);
    id_is_branch = 1'($urandom); id_br_if_zero = 1'($urandom);
    id_br_target = $urandom; rf_a_data = rnd_val();
    ex_src_a = RW'($urandom_range(0, 3)); ex_src_b = RW'($urandom_range(0, 3));
    ex_dst = RW'($urandom_range(0, 3)); ex_wr_en = 1'($urandom); ex_is_load = 1'($urandom);
    mem_dst = RW'($urandom_range(0, 3)); mem_wr_en = 1'($urandom); mem_is_load = 1'($urandom);
    exmem_result = rnd_val();
    wb_dst = RW'($urandom_range(0, 3)); wb_wr_en = 1'($urandom); memwb_result = rnd_val();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: quiet inputs give quiet outputs
    chk("R2 reset alu_a_sel", alu_a_sel, 2'b00);
    chk("R10 reset redirect", redirect, 1'b0);
    chk("R5 reset stall", stall, 1'b0);
    rst_n = 1'b1;

    // R3 directed: both stages write r2
    @(posedge clk); #1 idle();
    ex_src_a = 2; mem_dst = 2; mem_wr_en = 1; wb_dst = 2; wb_wr_en = 1;
    @(negedge clk); chk("R3 mem over wb", alu_a_sel, 2'b01);

    // R4 directed: r0 producers everywhere, load in EX
    @(posedge clk); #1 idle();
    ex_dst = 0; ex_wr_en = 1; ex_is_load = 1; mem_dst = 0; mem_wr_en = 1; wb_wr_en = 1;
    id_use_a = 1; id_use_b = 1;
    @(negedge clk); chk("R4 r0 no fwd", alu_a_sel, 2'b00); chk("R4 r0 no stall", stall, 1'b0);

    // R5 directed: unused matching source does not stall
    @(posedge clk); #1 idle();
    ex_dst = 3; ex_wr_en = 1; ex_is_load = 1; id_src_b = 3; id_use_b = 0;
    @(negedge clk); chk("R5 unused src", stall, 1'b0);

    // R6 directed: ALU result in EX, consumer in ID
    @(posedge clk); #1 ex_is_load = 0; id_use_b = 1;
    @(negedge clk); chk("R6 alu no stall", stall, 1'b0);

    // R7 walk: load r1 then beqz r1 (taken if zero), value arrives 0
    @(posedge clk); #1 idle();
    id_is_branch = 1; id_br_if_zero = 1; id_src_a = 1; id_use_a = 1; id_br_target = 32'h40;
    rf_a_data = 32'h5; ex_dst = 1; ex_wr_en = 1; ex_is_load = 1;
    @(negedge clk); chk("R7 load ahead stall 1", stall, 1'b1); chk("R10 no redirect", redirect, 1'b0);
    @(posedge clk); #1 ex_wr_en = 0; ex_is_load = 0; ex_dst = 0;
    mem_dst = 1; mem_wr_en = 1; mem_is_load = 1;
    @(negedge clk); chk("R7 load ahead stall 2", stall, 1'b1);
    @(posedge clk); #1 mem_wr_en = 0; mem_is_load = 0; mem_dst = 0;
    wb_dst = 1; wb_wr_en = 1; memwb_result = 0;
    @(negedge clk); chk("R7 resolved", stall, 1'b0); chk("R8 wb path", br_sel, 2'b10);
    chk("R9 taken", redirect, 1'b1); chk("R9 target", redirect_pc, 32'h40);

    // R7 walk: ALU producer ahead gives one stall, then EX/MEM forward
    @(posedge clk); #1 idle();
    id_is_branch = 1; id_br_if_zero = 0; id_src_a = 2; ex_dst = 2; ex_wr_en = 1;
    @(negedge clk); chk("R7 alu ahead stall", stall, 1'b1);
    @(posedge clk); #1 ex_wr_en = 0; ex_dst = 0; mem_dst = 2; mem_wr_en = 1; exmem_result = 7;
    @(negedge clk); chk("R7 alu resolved", stall, 1'b0); chk("R8 exmem path", br_sel, 2'b01);
    chk("R9 bnez taken", redirect, 1'b1);

    // random stream compared every clock
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1 randomize_inputs();
      @(negedge clk); compare_all();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule